// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a stream of packet bytes into a serial HDLC line bit stream. It pulls bytes through a valid/ready interface and sends each one least significant bit first. It starts every frame with a flag and ends it with a flag. Between the flags it inserts a zero after any five ones in a row, so frame content can never look like a flag or an abort. It can append a complemented 16-bit CRC as the frame check sequence. When no packet is waiting, it fills the line with flags sent back to back.

The line clock reaches the block as a one-cycle strobe. Each strobe produces exactly one line bit, and nothing advances between strobes. The source can cancel a packet by sending a beat with the abort marker set. If the source has no byte ready when the framer needs one in the middle of a frame, the framer reports an underflow and aborts the frame itself. A done pulse marks the last bit of each closing flag. That same flag may also serve as the opening flag of the next frame.

Back-pressure works as follows. `s_ready` is combinational and is high only in a strobe cycle in which the framer needs the next byte of a frame. A beat is consumed when `s_valid && s_ready`. Once the source raises `s_valid` for a packet, it must keep it high until the packet's last beat has been taken. A low `s_valid` at a byte request inside a frame counts as underflow.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `rst_n` is low, `tx_bit` is 1, and `s_ready`, `eop_done` and `underflow` are 0.
- R2: Outside a frame the line carries flags back to back. Each flag is the bit sequence 0,1,1,1,1,1,1,0 (0x7E sent LSB first). At the last bit of a flag, a high `s_valid` starts a frame, and that flag becomes the opening flag.
- R3: Data bytes are sent LSB first, one line bit per strobe. `s_ready` is high only in a strobe cycle that needs the first bit of a new frame byte. That bit is taken from `s_data[0]` in the same cycle.
- R4: After five consecutive 1 bits in the data or FCS part, one 0 bit is inserted. This includes the case just before the closing flag. Flag and abort bits are never stuffed and do not count toward a run.
- R5: The FCS register is preset to 0xFFFF at frame start. It is updated per data bit in reflected form with the constant 0x8408 (generator x^16+x^12+x^5+1). Its complement is sent as 16 bits, register bit 0 first, ahead of the closing flag. The bytes "123456789" give FCS 0x906E.
- R6: `fcs_inhibit` is sampled when a frame starts. If it is set, the closing flag follows the last data bit directly.
- R7: `eop_done` pulses for one cycle after the strobe that sends the last bit of a closing flag. That flag may open the next frame.
- R8: An accepted beat with `s_abort` set is discarded. The framer then sends eight 1 bits, with no `eop_done`, and returns to flags.
- R9: If `s_valid` is low when a frame byte is requested, `underflow` pulses for one cycle and the framer sends the same eight-ones abort.
- R10: `tx_bit` changes only after a strobe cycle. `eop_done` and `underflow` are 0 after any cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe, one line bit each |
| fcs_inhibit | input | 1 | Omit the FCS of the frame starting now |
| s_valid | input | 1 | Source beat valid |
| s_ready | output | 1 | Framer takes the beat this cycle |
| s_data | input | 8 | Packet byte |
| s_last | input | 1 | Beat is the packet's last byte |
| s_abort | input | 1 | Beat cancels the packet |
| tx_bit | output | 1 | Serial line bit |
| underflow | output | 1 | Pulse: byte missing mid-frame |
| eop_done | output | 1 | Pulse: closing flag finished |

## Verification
`s_ready` is due in the same cycle as the strobe that asks for a byte. `tx_bit`, `eop_done` and `underflow` are registered and are due one cycle after the strobe that produced them. The bench drives its inputs just after the falling edge. Once the inputs have settled, it compares `s_ready` against the reference model and advances the model by one step. At the next falling edge it compares the three registered outputs with the values the model predicted for that edge. The strobe pattern is changed between every cycle, every third cycle and a random pattern, so that hold behaviour and stuffing across strobe gaps are both exercised.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [1:0] {
    ST_FLAG  = 2'd0,
    ST_DATA  = 2'd1,
    ST_FCS   = 2'd2,
    ST_ABORT = 2'd3
  } tx_state_e;

  localparam logic [7:0] FLAG_PATTERN = 8'h7E;
endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    POLY = 16'h8408,
  parameter logic [W-1:0]    INIT = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         preset,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic         fb;
  logic [W-1:0] crc_next;

  // reflected serial update: feedback taken from bit 0
  always_comb begin
    fb       = crc[0] ^ din;
    crc_next = (crc >> 1) ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      crc <= INIT;
    else if (preset) crc <= INIT;
    else if (step)   crc <= crc_next;
  end
endmodule

// File: rtl/hdlc_tx_runlen.sv
module hdlc_tx_runlen #(
  parameter int RUN_MAX = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic bit_in,
  output logic stuff_due
);
  localparam int RW = $clog2(RUN_MAX + 1);

  logic [RW-1:0] run;

  assign stuff_due = (run == RW'(RUN_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n)      run <= '0;
    else if (clear)  run <= '0;
    else if (step)   run <= bit_in ? run + RW'(1) : '0;
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int               BYTE_W    = 8,
  parameter int               FCS_W     = 16,
  parameter logic [FCS_W-1:0] FCS_POLY  = 16'h8408,
  parameter int               RUN_MAX   = 5,
  parameter int               ABORT_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              fcs_inhibit,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  input  logic              s_abort,
  output logic              tx_bit,
  output logic              underflow,
  output logic              eop_done
);
  localparam int CNT_W = $clog2(FCS_W > BYTE_W ? FCS_W : BYTE_W);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] BYTE_END  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FCS_END   = CNT_W'(FCS_W - 1);
  localparam logic [CNT_W-1:0] ABORT_END = CNT_W'(ABORT_LEN - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  tx_state_e         state, state_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] shreg, shreg_n;
  logic              last_q, last_n, inhib_q, inhib_n, closing_q, closing_n;
  logic              bit_c, stuffable, take, eop_c, unf_c;
  logic              crc_step, crc_din, crc_preset, stuff_due;
  logic [FCS_W-1:0]  crc_q;

  hdlc_tx_crc #(.W(FCS_W), .POLY(FCS_POLY), .INIT('1)) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .preset (bit_en && crc_preset),
    .step   (bit_en && crc_step),
    .din    (crc_din),
    .crc    (crc_q)
  );

  hdlc_tx_runlen #(.RUN_MAX(RUN_MAX)) u_runlen (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (bit_en && !stuffable),
    .step      (bit_en && stuffable),
    .bit_in    (bit_c),
    .stuff_due (stuff_due)
  );

  always_comb begin
    state_n    = state;
    cnt_n      = cnt;
    shreg_n    = shreg;
    last_n     = last_q;
    inhib_n    = inhib_q;
    closing_n  = closing_q;
    bit_c      = 1'b1;
    stuffable  = 1'b0;
    take       = 1'b0;
    eop_c      = 1'b0;
    unf_c      = 1'b0;
    crc_step   = 1'b0;
    crc_din    = 1'b0;
    crc_preset = 1'b0;
    if (stuff_due) begin
      bit_c     = 1'b0;
      stuffable = 1'b1;
    end else begin
      unique case (state)
        ST_FLAG: begin
          bit_c = FLAG_PATTERN[cnt[IDX_W-1:0]];
          if (cnt == BYTE_END) begin
            cnt_n     = '0;
            eop_c     = closing_q;
            closing_n = 1'b0;
            if (s_valid) begin
              state_n    = ST_DATA;
              crc_preset = 1'b1;
              inhib_n    = fcs_inhibit;
            end
          end else begin
            cnt_n = cnt + ONE;
          end
        end
        ST_DATA: begin
          if (cnt == '0) begin
            take = 1'b1;
            if (!s_valid || s_abort) begin
              bit_c   = 1'b1;
              unf_c   = !s_valid;
              state_n = ST_ABORT;
              cnt_n   = ONE;
            end else begin
              bit_c     = s_data[0];
              shreg_n   = s_data;
              last_n    = s_last;
              stuffable = 1'b1;
              crc_step  = 1'b1;
              crc_din   = s_data[0];
              cnt_n     = ONE;
            end
          end else begin
            bit_c     = shreg[cnt[IDX_W-1:0]];
            stuffable = 1'b1;
            crc_step  = 1'b1;
            crc_din   = bit_c;
            if (cnt == BYTE_END) begin
              cnt_n = '0;
              if (last_q) begin
                state_n   = inhib_q ? ST_FLAG : ST_FCS;
                closing_n = inhib_q;
              end
            end else begin
              cnt_n = cnt + ONE;
            end
          end
        end
        ST_FCS: begin
          bit_c     = ~crc_q[cnt];
          stuffable = 1'b1;
          if (cnt == FCS_END) begin
            cnt_n     = '0;
            state_n   = ST_FLAG;
            closing_n = 1'b1;
          end else begin
            cnt_n = cnt + ONE;
          end
        end
        ST_ABORT: begin
          bit_c = 1'b1;
          if (cnt == ABORT_END) begin
            cnt_n   = '0;
            state_n = ST_FLAG;
          end else begin
            cnt_n = cnt + ONE;
          end
        end
        default: state_n = ST_FLAG;
      endcase
    end
  end

  assign s_ready = bit_en && take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_FLAG;
      cnt       <= '0;
      shreg     <= '0;
      last_q    <= 1'b0;
      inhib_q   <= 1'b0;
      closing_q <= 1'b0;
      tx_bit    <= 1'b1;
      eop_done  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      eop_done  <= bit_en && eop_c;
      underflow <= bit_en && unf_c;
      if (bit_en) begin
        state     <= state_n;
        cnt       <= cnt_n;
        shreg     <= shreg_n;
        last_q    <= last_n;
        inhib_q   <= inhib_n;
        closing_q <= closing_n;
        tx_bit    <= bit_c;
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic s_ready,
  input logic tx_bit,
  input logic underflow,
  input logic eop_done
);
  // R3
  ready_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bit_en);

  // R10
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  // R7
  eop_after_flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_done |-> !tx_bit);

  // R7
  eop_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_done |=> !eop_done);

  // R9
  underflow_sends_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (tx_bit && !eop_done));
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .s_ready   (s_ready),
  .tx_bit    (tx_bit),
  .underflow (underflow),
  .eop_done  (eop_done)
);

// File: tb/hdlc_tx_framer_bench.sv
module hdlc_tx_framer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, fcs_inhibit = 1'b0, s_valid = 1'b0, s_last = 1'b0, s_abort = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, tx_bit, underflow, eop_done;

  always #2.5 clk = ~clk;

  hdlc_tx_framer u_hdlc_tx_framer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fcs_inhibit(fcs_inhibit),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .s_abort(s_abort), .tx_bit(tx_bit), .underflow(underflow), .eop_done(eop_done)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, div = 1;
  logic inh_ctl = 1'b0;
  bit done = 0;
  logic [9:0] src[$];   // {abort, last, data}
  logic [7:0] q[$];     // {tag[3:0], eop, flag_end, stuffable, bit}

  // reference model state
  int ones = 0, tag = 2;
  bit in_frame = 0, closing = 0, inhib = 0;
  logic [15:0] mcrc = 16'hFFFF;
  logic exp_bit = 1'b1, exp_eop = 1'b0, exp_unf = 1'b0, exp_ready = 1'b0;

  function automatic string tname(int t);
    case (t)
      2: return "R2"; 3: return "R3"; 4: return "R4"; 5: return "R5";
      6: return "R6"; 7: return "R7"; 8: return "R8"; 9: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] d);
    for (int i = 0; i < 8; i++) c = (c >> 1) ^ ((c[0] ^ d[i]) ? 16'h8408 : 16'h0);
    return c;
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", rq, act, exp, cyc);
    end
  endtask

  task automatic model_step();
    logic [7:0] it;
    bit skip_pop = 0;
    exp_ready = 1'b0;
    exp_eop = 1'b0;
    exp_unf = 1'b0;
    if (!bit_en) begin
      tag = 10;
      return;
    end
    if (ones == 5) begin
      exp_bit = 1'b0; ones = 0; tag = 4;
      return;
    end
    if (q.size() == 0) begin
      if (in_frame) begin
        exp_ready = 1'b1;
        if (!s_valid || s_abort) begin
          exp_unf = !s_valid;
          exp_bit = 1'b1;
          tag = s_valid ? 8 : 9;
          for (int i = 0; i < 7; i++) q.push_back({4'(tag), 4'b0001});
          in_frame = 0; ones = 0; skip_pop = 1;
        end else begin
          for (int i = 0; i < 8; i++) q.push_back({4'd3, 2'b00, 1'b1, s_data[i]});
          mcrc = crc_byte(mcrc, s_data);
          if (s_last) begin
            if (!inhib)
              for (int i = 0; i < 16; i++) q.push_back({4'd5, 2'b00, 1'b1, ~mcrc[i]});
            in_frame = 0; closing = 1;
          end
        end
      end else begin
        for (int i = 0; i < 8; i++)
          q.push_back({4'(closing ? (inhib ? 6 : 7) : 2), (i == 7) && closing, i == 7,
                       1'b0, 8'h7E >> i & 8'h01 ? 1'b1 : 1'b0});
        closing = 0;
      end
    end
    if (!skip_pop) begin
      it = q.pop_front();
      exp_bit = it[0];
      tag = int'(it[7:4]);
      if (it[1]) ones = it[0] ? ones + 1 : 0; else ones = 0;
      exp_eop = it[3];
      if (it[2] && s_valid) begin
        in_frame = 1; mcrc = 16'hFFFF; inhib = fcs_inhibit;
      end
    end
  endtask

  task automatic drive();
    cyc++;
    bit_en = (div == 0) ? 1'($urandom_range(0, 1)) : ((cyc % div) == 0);
    s_valid = src.size() > 0;
    {s_abort, s_last, s_data} = s_valid ? src[0] : 10'h0;
    fcs_inhibit = inh_ctl;
  endtask

  // driver, model and comparison
  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(tx_bit === 1'b1, "R1", tx_bit, 1);
      chk(s_ready === 1'b0 && eop_done === 1'b0 && underflow === 1'b0, "R1",
          {s_ready, eop_done, underflow}, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    drive(); #1; model_step();
    while (!done && cyc < 150000) begin
      @(negedge clk);
      chk(tx_bit === exp_bit, tname(tag), tx_bit, exp_bit);
      chk(eop_done === exp_eop, "R7", eop_done, exp_eop);
      chk(underflow === exp_unf, "R9", underflow, exp_unf);
      drive(); #1;
      model_step();
      chk(s_ready === exp_ready, "R3", s_ready, exp_ready);
      if (exp_ready && s_valid) void'(src.pop_front());
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic put(logic [7:0] d, bit last, bit ab);
    src.push_back({ab, last, d});
  endtask

  task automatic drain();
    while (src.size() != 0) @(posedge clk);
    repeat (400) @(posedge clk);
  endtask

  // stimulus
  initial begin
    string kat;
    logic [15:0] c;
    kat = "123456789";
    c = 16'hFFFF;
    for (int i = 0; i < 9; i++) c = crc_byte(c, kat[i]);
    chk(~c === 16'h906E, "R5", ~c, 16'h906E);
    wait (rst_n);
    repeat (40) @(posedge clk);                    // R2 idle flags
    for (int i = 0; i < 9; i++) put(kat[i], i == 8, 0);   // R5 known frame
    drain();
    div = 3;                                       // R4 and R10 with gaps
    put(8'hFF, 0, 0); put(8'hFF, 0, 0); put(8'h7E, 0, 0); put(8'hF8, 1, 0);
    drain();
    inh_ctl = 1'b1;                                // R6
    put(8'h1F, 0, 0); put(8'hFF, 1, 0);
    drain();
    inh_ctl = 1'b0;
    div = 1;                                       // R7 shared flag
    put(8'h01, 0, 0); put(8'h80, 1, 0); put(8'hC3, 0, 0); put(8'h55, 1, 0);
    drain();
    put(8'hA5, 0, 0); put(8'h3C, 0, 0); put(8'h00, 0, 1);   // R8
    put(8'h5A, 1, 0);
    drain();
    div = 2;                                       // R9 underflow
    put(8'hE7, 0, 0); put(8'h18, 0, 0);
    drain();
    div = 0;                                       // random strobes
    put(8'h3E, 1, 0);
    inh_ctl = 1'b1;
    drain();
    inh_ctl = 1'b0;
    put(8'hFE, 0, 0); put(8'hFF, 1, 0);
    drain();
    done = 1;
  end
endmodule